// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a purely combinational shifter and rotator for an integer datapath of configurable width. A source operand, a shift count, an incoming carry flag and a three-bit operation code go in. The shifted or rotated value, the updated carry flag and a zero flag come out in the same cycle. The carry flag always ends up holding the last bit that left the operand.

There are eight operations: two left shifts (logical and arithmetic, which behave the same), two right shifts (zero fill and sign fill), two plain rotates and two rotates that treat the carry flag as one extra bit of the rotated value. Only the low five bits of the count are used. A count of zero leaves both the operand and the carry untouched. The zero flag is reported for the four shift operations only.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 is a logical left shift: the result is the operand moved up by the count, with zeros entering at bit 0 and bits beyond the width discarded.
- R2: Operation code 1 is an arithmetic left shift and gives exactly the same result, carry and zero flag as code 0 for every input.
- R3: Operation code 2 is a logical right shift: the operand moves down by the count and zeros fill the vacated upper bits.
- R4: Operation code 3 is an arithmetic right shift: vacated upper bits take copies of the operand's top bit.
- R5: For a nonzero count, every shift puts the last bit shifted out into the carry. That bit is 0 for codes 0 to 2 once the count exceeds the width, and it is the sign bit for code 3.
- R6: Codes 4 (left) and 5 (right) rotate the operand by the count modulo the width. The carry takes the last bit rotated: result bit 0 after a left rotate, and the top result bit after a right rotate.
- R7: Codes 6 (left) and 7 (right) rotate the width-plus-one value formed by the carry (top) above the operand, by the count modulo width plus one. The new carry is the top bit of that value.
- R8: Only bits 4:0 of the count input are used. Any value in the upper count bits gives the same outputs.
- R9: A masked count of zero returns the operand unchanged and passes the incoming carry straight to the carry output, for every operation.
- R10: The zero flag is 1 exactly when a shift (codes 0 to 3) gives an all-zero result. It is 0 for all rotate codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcIn | input | W | Operand to shift or rotate |
| amtIn | input | AMT_W | Shift count; only bits 4:0 are used |
| carryIn | input | 1 | Incoming carry flag |
| opSel | input | 3 | Operation code 0 to 7 |
| resultOut | output | W | Shifted or rotated value |
| carryOut | output | 1 | Updated carry flag |
| zeroOut | output | 1 | All-zero result flag for shift codes |

## Verification
The checks are immediate and evaluated on settled combinational values. They therefore assume each input vector is held steady until the outputs have resolved, and that operation codes, counts and carries are always at known 0/1 values. The bench drives a new vector only on the falling clock edge and samples a quarter period later. It uses only fully specified vectors: an exhaustive sweep of every code against every masked count, seeded random operands and counts with random upper count bits, and directed all-zero, all-one and single-bit operands.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_LSL  = 3'd0,
    OP_ASL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROTL = 3'd4,
    OP_ROTR = 3'd5,
    OP_RCYL = 3'd6,
    OP_RCYR = 3'd7
  } shrot_op_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic goLeft;    // direction of motion
    logic signFill;  // right shift copies the top bit
    logic rotate;    // bits wrap around instead of dropping
    logic viaCarry;  // carry joins the rotated value
    logic isShift;   // zero flag is reported
  } shrot_ctrl_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [2:0]  opSel,
  output shrot_ctrl_t ctrl
);

  shrot_op_e op;
  assign op = shrot_op_e'(opSel);

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_LSL, OP_ASL: begin ctrl.goLeft = 1'b1; ctrl.isShift = 1'b1; end
      OP_LSR:         begin ctrl.isShift = 1'b1; end
      OP_ASR:         begin ctrl.isShift = 1'b1; ctrl.signFill = 1'b1; end
      OP_ROTL:        begin ctrl.rotate = 1'b1; ctrl.goLeft = 1'b1; end
      OP_ROTR:        begin ctrl.rotate = 1'b1; end
      OP_RCYL:        begin ctrl.rotate = 1'b1; ctrl.viaCarry = 1'b1; ctrl.goLeft = 1'b1; end
      OP_RCYR:        begin ctrl.rotate = 1'b1; ctrl.viaCarry = 1'b1; end
      default:        ctrl = '0;
    endcase
  end

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int W        = 16,
  parameter int CNT_BITS = 5
) (
  input  logic [W-1:0]        srcIn,
  input  logic [CNT_BITS-1:0] cnt,
  input  logic                carryIn,
  input  shrot_ctrl_t         ctrl,
  output logic [W-1:0]        resultOut,
  output logic                carryOut,
  output logic                zeroOut
);

  localparam int SPAN = 1 << CNT_BITS;
  localparam int RCW  = W + 1;

  // Shift paths: a guard bit catches the last bit that leaves
  logic [W+SPAN-1:0] leftWide;
  logic [W+SPAN:0]   rightWide;
  logic              fillBit;

  assign fillBit   = ctrl.signFill & srcIn[W-1];
  assign leftWide  = {{SPAN{1'b0}}, srcIn} << cnt;
  assign rightWide = {{SPAN{fillBit}}, srcIn, 1'b0} >> cnt;

  // Plain rotate over a doubled copy
  int unsigned        rotAmt;
  logic [2*W-1:0]     dbl, rotLWide, rotRWide;
  assign rotAmt   = 32'(cnt) % W;
  assign dbl      = {srcIn, srcIn};
  assign rotLWide = dbl << rotAmt;
  assign rotRWide = dbl >> rotAmt;

  // Rotate through carry over a width-plus-one value
  int unsigned        rcAmt;
  logic [2*RCW-1:0]   dblC, rcLWide, rcRWide;
  assign rcAmt   = 32'(cnt) % RCW;
  assign dblC    = {carryIn, srcIn, carryIn, srcIn};
  assign rcLWide = dblC << rcAmt;
  assign rcRWide = dblC >> rcAmt;

  always_comb begin
    resultOut = srcIn;
    carryOut  = carryIn;
    if (cnt != '0) begin
      if (!ctrl.rotate) begin
        if (ctrl.goLeft) begin
          resultOut = leftWide[W-1:0];
          carryOut  = leftWide[W];
        end else begin
          resultOut = rightWide[W:1];
          carryOut  = rightWide[0];
        end
      end else if (ctrl.viaCarry) begin
        if (ctrl.goLeft) begin
          resultOut = rcLWide[2*RCW-2:RCW];
          carryOut  = rcLWide[2*RCW-1];
        end else begin
          resultOut = rcRWide[W-1:0];
          carryOut  = rcRWide[W];
        end
      end else begin
        if (ctrl.goLeft) begin
          resultOut = rotLWide[2*W-1:W];
          carryOut  = rotLWide[W];
        end else begin
          resultOut = rotRWide[W-1:0];
          carryOut  = rotRWide[W-1];
        end
      end
    end
  end

  assign zeroOut = ctrl.isShift && (resultOut == '0);

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W        = 16,
  parameter int AMT_W    = 8,
  parameter int CNT_BITS = 5
) (
  input  logic [W-1:0]     srcIn,
  input  logic [AMT_W-1:0] amtIn,
  input  logic             carryIn,
  input  logic [2:0]       opSel,
  output logic [W-1:0]     resultOut,
  output logic             carryOut,
  output logic             zeroOut
);

  shrot_ctrl_t         ctrl;
  logic [CNT_BITS-1:0] cnt;

  generate
    if (AMT_W > CNT_BITS) begin : g_mask
      logic unusedAmtHigh;
      assign unusedAmtHigh = ^amtIn[AMT_W-1:CNT_BITS];
      assign cnt = amtIn[CNT_BITS-1:0];
    end else begin : g_pad
      assign cnt = CNT_BITS'(amtIn);
    end
  endgenerate

  shrot_ctrl ctrl_i (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  shrot_datapath #(.W(W), .CNT_BITS(CNT_BITS)) dp_i (
    .srcIn     (srcIn),
    .cnt       (cnt),
    .carryIn   (carryIn),
    .ctrl      (ctrl),
    .resultOut (resultOut),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut)
  );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int W        = 16,
  parameter int AMT_W    = 8,
  parameter int CNT_BITS = 5
) (
  input logic [W-1:0]     srcIn,
  input logic [AMT_W-1:0] amtIn,
  input logic             carryIn,
  input logic [2:0]       opSel,
  input logic [W-1:0]     resultOut,
  input logic             carryOut,
  input logic             zeroOut
);

  logic [CNT_BITS-1:0] chkCnt;
  logic                unusedChkHigh;
  assign chkCnt        = CNT_BITS'(amtIn);
  assign unusedChkHigh = ^amtIn;

  always_comb begin
    if (chkCnt == '0) begin
      AST_ZERO_COUNT_KEEP: assert (resultOut == srcIn && carryOut == carryIn)
        else $error("zero count altered state"); // R9
    end
    if (zeroOut) begin
      AST_ZERO_FLAG_SHIFT: assert (opSel[2] == 1'b0 && resultOut == '0)
        else $error("zero flag on rotate or nonzero result"); // R10
    end
    if (opSel[2:1] == 2'b00 && chkCnt != '0) begin
      AST_LEFT_FILL_ZERO: assert (resultOut[0] == 1'b0)
        else $error("left shift did not fill zero"); // R1
    end
    if (opSel == 3'd3) begin
      AST_ASR_SIGN_KEPT: assert (resultOut[W-1] == srcIn[W-1])
        else $error("sign fill lost top bit"); // R4
    end
    if (opSel[2:1] == 2'b10) begin
      AST_ROT_POP_KEPT: assert ($countones(resultOut) == $countones(srcIn))
        else $error("plain rotate changed bit count"); // R6
    end
    if (opSel[2:1] == 2'b11) begin
      AST_RCY_POP_KEPT: assert ($countones({carryOut, resultOut}) == $countones({carryIn, srcIn}))
        else $error("carry rotate changed bit count"); // R7
    end
  end

endmodule

bind shrot_unit shrot_unit_chk #(.W(W), .AMT_W(AMT_W), .CNT_BITS(CNT_BITS)) chk_i (.*);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;

  localparam int W     = 16;
  localparam int AMT_W = 8;

  logic             clk = 1'b0;
  logic [W-1:0]     srcIn;
  logic [AMT_W-1:0] amtIn;
  logic             carryIn;
  logic [2:0]       opSel;
  logic [W-1:0]     resultOut;
  logic             carryOut;
  logic             zeroOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shrot_unit #(.W(W), .AMT_W(AMT_W)) dut_i (
    .srcIn(srcIn), .amtIn(amtIn), .carryIn(carryIn), .opSel(opSel),
    .resultOut(resultOut), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  // Step-by-step reference: one bit position per iteration
  function automatic logic [W+1:0] model(input logic [W-1:0] v0, input logic [AMT_W-1:0] a,
                                         input logic c0, input logic [2:0] op);
    logic [W-1:0] v = v0;
    logic c = c0;
    logic nc;
    int n = int'(a) & 31;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0, 3'd1: begin nc = v[W-1]; v = v << 1; end
        3'd2:       begin nc = v[0];   v = v >> 1; end
        3'd3:       begin nc = v[0];   v = {v[W-1], v[W-1:1]}; end
        3'd4:       begin nc = v[W-1]; v = {v[W-2:0], v[W-1]}; end
        3'd5:       begin nc = v[0];   v = {v[0], v[W-1:1]}; end
        3'd6:       begin nc = v[W-1]; v = {v[W-2:0], c}; end
        default:    begin nc = v[0];   v = {c, v[W-1:1]}; end
      endcase
      c = nc;
    end
    return {(op < 3'd4) && (v == '0), c, v};
  endfunction

  function automatic string reqOf(input logic [2:0] op, input logic [AMT_W-1:0] a);
    if ((a & 8'h1F) == 0) return "R9";
    case (op)
      3'd0: return "R1/R5";
      3'd1: return "R2/R5";
      3'd2: return "R3/R5";
      3'd3: return "R4/R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] s, input logic [AMT_W-1:0] a,
                       input logic c, input logic [2:0] op, input string tag);
    logic [W+1:0] exp;
    @(negedge clk);
    srcIn = s; amtIn = a; carryIn = c; opSel = op;
    #2;
    exp = model(s, a, c, op);
    checks++;
    if ({carryOut, resultOut} !== exp[W:0]) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d src=%h cin=%0b: got carry=%0b res=%h, expected carry=%0b res=%h",
               (tag == "") ? reqOf(op, a) : tag, op, a, s, c, carryOut, resultOut, exp[W], exp[W-1:0]);
    end
    checks++;
    if (zeroOut !== exp[W+1]) begin
      fails++;
      $display("FAIL R10 op=%0d amt=%0d src=%h: got zero=%0b, expected zero=%0b",
               op, a, s, zeroOut, exp[W+1]);
    end
  endtask

  initial begin
    logic [W-1:0] pats [4];
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    pats[0] = 16'hB3C5; pats[1] = 16'h0000; pats[2] = 16'hFFFF; pats[3] = 16'h8001;
    srcIn = '0; amtIn = '0; carryIn = 1'b0; opSel = 3'd0;

    // Initial state with all-zero inputs (R9, R10)
    @(negedge clk); #2;
    checks++;
    if (resultOut !== '0 || carryOut !== 1'b0 || zeroOut !== 1'b1) begin
      fails++;
      $display("FAIL R9 initial: got res=%h carry=%0b zero=%0b, expected 0000 0 1",
               resultOut, carryOut, zeroOut);
    end

    // Every code against every masked count, both carry values
    for (int p = 0; p < 4; p++)
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < 32; a++)
          for (int c = 0; c < 2; c++)
            apply(pats[p], AMT_W'(a), c[0], op[2:0], "");

    // Single-bit operand walking through rotates and shifts
    for (int b = 0; b < W; b++)
      for (int op = 0; op < 8; op++)
        apply(W'(1) << b, AMT_W'(b + 1), 1'b1, op[2:0], "");

    // Upper count bits set must be ignored (R8)
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] s = W'($urandom);
      logic [AMT_W-1:0] a = AMT_W'($urandom) | 8'h20;
      apply(s, a, 1'($urandom), 3'($urandom), "R8");
    end

    // Random mix
    for (int i = 0; i < 2000; i++)
      apply(W'($urandom), AMT_W'($urandom), 1'($urandom), 3'($urandom), "");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule